// File: doc/BRIEF.md
# SPI NOR Flash Command Monitor

A passive observer for a byte-level SPI link to a serial NOR flash. Each transfer arrives as one controller-to-flash byte and one flash-to-controller byte with a valid strobe, together with the chip-select level (high means the flash is selected). The monitor takes the opcode from the first byte of each command and walks a per-opcode byte sequence. It assembles the 24-bit address and emits one structured event per interesting byte on a valid/ready output.

Each event carries a type code, the (normalised) opcode, a 24-bit address field and an 8-bit data field. The monitor drives nothing onto the SPI link. If the event consumer stalls, the pending event is held, newer events are dropped and a sticky overflow flag is raised.

The controller is a state machine with states IDLE (waiting for an opcode), ADDR (address bytes), DUMMY (the one dummy byte of a fast read), XFER (read or program data), ID (identification reply), STAT (status reply) and WSTAT (write-status value). Its transitions are:
- IDLE to ADDR on read 0x03, fast read 0x0B, page program 0x02, sector erase 0x20 or block erase 0xD8.
- IDLE to ID on 0x9F, IDLE to STAT on 0x05, and IDLE to WSTAT on 0x01.
- IDLE stays in IDLE on a single-byte or unknown opcode.
- ADDR to XFER (read, program), ADDR to DUMMY (fast read), and ADDR to IDLE (erases) on the fourth byte.
- DUMMY to XFER on the next byte.
- ID to IDLE after the third reply byte.
- WSTAT to IDLE after its value byte.
- Any state to IDLE whenever chip select is low.

Top module: `spi_flash_cmd_monitor`

## Requirements
- R1: After reset `evt_valid` and `overflow` are 0.
- R2: In IDLE, an accepted byte (chip select high and `byte_valid` high) is the opcode. A known opcode gives a command event: type 1, opcode field equal to the normalised opcode, address 0, and data equal to the raw byte.
- R3: Opcodes 0x60 and 0xC7 are both chip erase and are reported with opcode field 0x60. The event output never shows opcode 0xC7.
- R4: For 0x03, 0x0B, 0x02, 0x20 and 0xD8, bytes 2 to 4 on MOSI form a 24-bit address, most significant byte first. On byte 4 an address event is produced: type 2, address equal to that value, data 0.
- R5: For sector erase 0x20, an address whose low 12 bits are not zero gives a misalignment warning instead of the address event. The warning has type 8 and the address in the address field.
- R6: Data bytes carry the captured address in the address field. For read 0x03 they start at byte 5 and are taken from MISO (type 3). For page program 0x02 they start at byte 5 and are taken from MOSI (type 4). For fast read 0x0B, byte 5 is a dummy byte that gives no event, and MISO data (type 3) follows from byte 6.
- R7: A byte in IDLE that is not a known opcode gives an unknown event: type 7, with opcode and data fields equal to that byte. The next byte of the same frame is decoded as an opcode.
- R8: Write enable 0x06, write disable 0x04 and chip erase complete on the opcode byte. The next byte in the same frame is decoded as an opcode.
- R9: Read ID 0x9F gives three ID events (type 5, data from MISO, address field 1, 2, 3) and then completes. Read status 0x05 gives a status event (type 6, data from MISO) for every further byte until chip select drops. Write status 0x01 gives one type-4 event with the MOSI value and completes.
- R10: Chip select low ends any command and resets the byte position. Bytes strobed while chip select is low are ignored. The first byte after chip select rises is decoded as an opcode.
- R11: If chip select drops while a command is still in its address phase, a truncation event is produced: type 9, the command's opcode, the address bits gathered so far, and data equal to the number of bytes seen including the opcode.
- R12: While `evt_valid` is high and `evt_ready` is low, the event is held unchanged. A new event in that state is dropped and sets `overflow`, which stays set until reset.
- R13: The byte-position counter saturates at its maximum. A data burst longer than the counter range keeps producing data events and never re-enters opcode decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_active | input | 1 | Flash selected (high) |
| byte_valid | input | 1 | One transferred byte pair is present |
| mosi_byte | input | 8 | Byte sent to the flash |
| miso_byte | input | 8 | Byte returned by the flash |
| evt_valid | output | 1 | Event available |
| evt_ready | input | 1 | Consumer accepts the event |
| evt_type | output | 4 | Event type code |
| evt_opcode | output | 8 | Normalised opcode of the command |
| evt_addr | output | 24 | Address or index field |
| evt_data | output | 8 | Data field |
| overflow | output | 1 | Sticky: an event was dropped |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that `evt_ready` may be held low for any time. They also assume that a byte strobed while chip select is low is meaningless, so the counter and state checks treat chip select low as an unconditional frame end. The stimulus changes inputs only on the falling clock edge and leaves an idle cycle between bytes. It strobes a byte with chip select low only in the one scenario that checks such bytes are ignored, and it stalls the event output only in the final scenario, so the sticky overflow flag does not mask earlier checks.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

    localparam int ADDR_BYTES = 3;
    localparam int ADDR_W     = ADDR_BYTES * 8;
    localparam int SECTOR_LSB = 12;

    typedef enum logic [3:0] {
        EV_NONE    = 4'd0,
        EV_CMD     = 4'd1,
        EV_ADDR    = 4'd2,
        EV_RDATA   = 4'd3,
        EV_WDATA   = 4'd4,
        EV_ID      = 4'd5,
        EV_STATUS  = 4'd6,
        EV_UNKNOWN = 4'd7,
        EV_MISALIGN= 4'd8,
        EV_TRUNC   = 4'd9
    } evt_kind_e;

    typedef struct packed {
        evt_kind_e          kind;
        logic [7:0]         op;
        logic [ADDR_W-1:0]  addr;
        logic [7:0]         data;
    } evt_t;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_DUMMY, S_XFER, S_ID, S_STAT, S_WSTAT
    } mon_state_e;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDID  = 8'h9F;
    localparam logic [7:0] OP_RDST  = 8'h05;
    localparam logic [7:0] OP_WRST  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_FREAD = 8'h0B;
    localparam logic [7:0] OP_SERASE= 8'h20;
    localparam logic [7:0] OP_BERASE= 8'hD8;
    localparam logic [7:0] OP_CERASE= 8'h60;
    localparam logic [7:0] OP_CERALT= 8'hC7;
    localparam logic [7:0] OP_PROG  = 8'h02;

    function automatic evt_t mk_evt(evt_kind_e k, logic [7:0] o,
                                    logic [ADDR_W-1:0] a, logic [7:0] d);
        evt_t e;
        e.kind = k;
        e.op   = o;
        e.addr = a;
        e.data = d;
        return e;
    endfunction

endpackage

// File: rtl/spi_mon_pos_counter.sv
module spi_mon_pos_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] pos
);
    localparam logic [W-1:0] POS_MAX = '1;

    logic [W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pos_q <= '0;
        end else if (inc && pos_q != POS_MAX) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    assign pos = pos_q;

    // R13: a full counter stays full while bytes keep arriving
    a_r13_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == POS_MAX && inc && !clr) |=> pos_q == POS_MAX);

    // R13: without a clear the position never moves backwards
    a_r13_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr) |=> pos_q >= $past(pos_q));

endmodule

// File: rtl/spi_mon_decoder.sv
module spi_mon_decoder
    import spi_mon_pkg::*;
#(
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_active,
    input  logic             byte_valid,
    input  logic [7:0]       mosi_byte,
    input  logic [7:0]       miso_byte,
    input  logic [POS_W-1:0] pos,
    output logic             pos_clr,
    output logic             pos_inc,
    output logic             req_valid,
    output evt_t             req
);
    localparam logic [POS_W-1:0] LAST_ADDR_POS = POS_W'(ADDR_BYTES);

    mon_state_e        state_q, state_d;
    logic [7:0]        cmd_q, cmd_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              done;
    logic [ADDR_W-1:0] full_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cmd_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
            addr_q  <= addr_d;
        end
    end

    assign full_addr = {addr_q[ADDR_W-9:0], mosi_byte};

    always_comb begin
        state_d   = state_q;
        cmd_d     = cmd_q;
        addr_d    = addr_q;
        req_valid = 1'b0;
        req       = mk_evt(EV_NONE, 8'h00, '0, 8'h00);
        done      = 1'b0;
        if (!cs_active) begin
            state_d = S_IDLE;
            if (state_q == S_ADDR) begin
                req_valid = 1'b1;
                req = mk_evt(EV_TRUNC, cmd_q, addr_q, 8'(pos));
            end
        end else if (byte_valid) begin
            unique case (state_q)
                S_IDLE: begin
                    req_valid = 1'b1;
                    req = mk_evt(EV_CMD, mosi_byte, '0, mosi_byte);
                    cmd_d = mosi_byte;
                    addr_d = '0;
                    unique case (mosi_byte)
                        OP_WREN, OP_WRDI, OP_CERASE: done = 1'b1;
                        OP_CERALT: begin
                            req.op = OP_CERASE;
                            cmd_d  = OP_CERASE;
                            done   = 1'b1;
                        end
                        OP_READ, OP_FREAD, OP_PROG, OP_SERASE, OP_BERASE:
                            state_d = S_ADDR;
                        OP_RDID: state_d = S_ID;
                        OP_RDST: state_d = S_STAT;
                        OP_WRST: state_d = S_WSTAT;
                        default: begin
                            req  = mk_evt(EV_UNKNOWN, mosi_byte, '0, mosi_byte);
                            done = 1'b1;
                        end
                    endcase
                end
                S_ADDR: begin
                    addr_d = full_addr;
                    if (pos == LAST_ADDR_POS) begin
                        req_valid = 1'b1;
                        req = mk_evt(EV_ADDR, cmd_q, full_addr, 8'h00);
                        unique case (cmd_q)
                            OP_SERASE: begin
                                if (full_addr[SECTOR_LSB-1:0] != '0)
                                    req.kind = EV_MISALIGN;
                                done = 1'b1;
                            end
                            OP_BERASE: done = 1'b1;
                            OP_FREAD:  state_d = S_DUMMY;
                            default:   state_d = S_XFER;
                        endcase
                    end
                end
                S_DUMMY: state_d = S_XFER;
                S_XFER: begin
                    req_valid = 1'b1;
                    if (cmd_q == OP_PROG)
                        req = mk_evt(EV_WDATA, cmd_q, addr_q, mosi_byte);
                    else
                        req = mk_evt(EV_RDATA, cmd_q, addr_q, miso_byte);
                end
                S_ID: begin
                    req_valid = 1'b1;
                    req = mk_evt(EV_ID, cmd_q, ADDR_W'(pos), miso_byte);
                    if (pos == LAST_ADDR_POS) done = 1'b1;
                end
                S_STAT: begin
                    req_valid = 1'b1;
                    req = mk_evt(EV_STATUS, cmd_q, '0, miso_byte);
                end
                S_WSTAT: begin
                    req_valid = 1'b1;
                    req = mk_evt(EV_WDATA, cmd_q, '0, mosi_byte);
                    done = 1'b1;
                end
                default: state_d = S_IDLE;
            endcase
            if (done) state_d = S_IDLE;
        end
    end

    assign pos_clr = !cs_active || done;
    assign pos_inc = cs_active && byte_valid;

    // R10: a deselected flash always leaves the walker idle
    a_r10_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> state_q == S_IDLE);

    // R10: a strobe without chip select produces nothing but a truncation
    a_r10_no_event_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_active && req_valid) |-> req.kind == EV_TRUNC);

    // R4: the address phase never outlives its three bytes
    a_r4_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADDR) |-> pos <= LAST_ADDR_POS);

endmodule

// File: rtl/spi_mon_evt_port.sv
module spi_mon_evt_port
    import spi_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  evt_t req,
    input  logic ready,
    output logic valid,
    output evt_t evt,
    output logic overflow
);
    logic free;

    assign free = !valid || ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            evt      <= '0;
            overflow <= 1'b0;
        end else begin
            if (req_valid && free) begin
                valid <= 1'b1;
                evt   <= req;
            end else if (ready) begin
                valid <= 1'b0;
            end
            if (req_valid && !free) overflow <= 1'b1;
        end
    end

    // R12: overflow is sticky
    a_r12_sticky_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R12: a stalled event is held unchanged
    a_r12_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(evt)));

endmodule

// File: rtl/spi_flash_cmd_monitor.sv
module spi_flash_cmd_monitor
    import spi_mon_pkg::*;
#(
    parameter int POS_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_active,
    input  logic        byte_valid,
    input  logic [7:0]  mosi_byte,
    input  logic [7:0]  miso_byte,
    output logic        evt_valid,
    input  logic        evt_ready,
    output logic [3:0]  evt_type,
    output logic [7:0]  evt_opcode,
    output logic [23:0] evt_addr,
    output logic [7:0]  evt_data,
    output logic        overflow
);
    logic [POS_W-1:0] pos;
    logic             pos_clr;
    logic             pos_inc;
    logic             req_valid;
    evt_t             req;
    evt_t             evt;

    spi_mon_pos_counter #(.W(POS_W)) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pos_clr),
        .inc   (pos_inc),
        .pos   (pos)
    );

    spi_mon_decoder #(.POS_W(POS_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_active  (cs_active),
        .byte_valid (byte_valid),
        .mosi_byte  (mosi_byte),
        .miso_byte  (miso_byte),
        .pos        (pos),
        .pos_clr    (pos_clr),
        .pos_inc    (pos_inc),
        .req_valid  (req_valid),
        .req        (req)
    );

    spi_mon_evt_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req       (req),
        .ready     (evt_ready),
        .valid     (evt_valid),
        .evt       (evt),
        .overflow  (overflow)
    );

    assign evt_type   = evt.kind;
    assign evt_opcode = evt.op;
    assign evt_addr   = evt.addr;
    assign evt_data   = evt.data;

    // R3: the alternate chip-erase code never reaches the output
    a_r3_no_alt_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> evt_opcode != OP_CERALT);

    // R5: a misalignment warning always carries an unaligned address
    a_r5_misalign_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_type == 4'd8) |-> evt_addr[SECTOR_LSB-1:0] != '0);

    // R1: nothing is pending in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!evt_valid && !overflow));

endmodule

// File: tb/spi_flash_cmd_monitor_bench.sv
module spi_flash_cmd_monitor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_active = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  mosi_byte = 8'h00;
    logic [7:0]  miso_byte = 8'h00;
    logic        evt_valid;
    logic        evt_ready = 1'b1;
    logic [3:0]  evt_type;
    logic [7:0]  evt_opcode;
    logic [23:0] evt_addr;
    logic [7:0]  evt_data;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [43:0] seen[$];

    always #5 clk = ~clk;

    spi_flash_cmd_monitor u_spi_flash_cmd_monitor (
        .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .byte_valid(byte_valid),
        .mosi_byte(mosi_byte), .miso_byte(miso_byte), .evt_valid(evt_valid),
        .evt_ready(evt_ready), .evt_type(evt_type), .evt_opcode(evt_opcode),
        .evt_addr(evt_addr), .evt_data(evt_data), .overflow(overflow)
    );

    always @(negedge clk)
        if (rst_n && evt_valid && evt_ready)
            seen.push_back({evt_type, evt_opcode, evt_addr, evt_data});

    task automatic chk(bit ok, string tag, logic [43:0] act, logic [43:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_evt(string tag, logic [3:0] t, logic [7:0] o,
                              logic [23:0] a, logic [7:0] d);
        logic [43:0] exp;
        logic [43:0] act;
        exp = {t, o, a, d};
        act = '1;
        if (seen.size() != 0) act = seen.pop_front();
        chk(act == exp, tag, act, exp);
    endtask

    task automatic expect_none(string tag);
        chk(seen.size() == 0, tag, 44'(seen.size()), 44'd0);
        seen.delete();
    endtask

    task automatic xfer(logic [7:0] mo, logic [7:0] mi);
        @(negedge clk);
        byte_valid = 1'b1;
        mosi_byte  = mo;
        miso_byte  = mi;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic cs_on();
        @(negedge clk);
        cs_active = 1'b1;
    endtask

    task automatic cs_off();
        @(negedge clk);
        cs_active = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!evt_valid && !overflow, "R1 reset state",
            44'({evt_valid, overflow}), 44'd0);
        expect_none("R1 no events after reset");
    endtask

    task automatic t_single();
        cs_on();
        xfer(8'h06, 8'h00);
        xfer(8'h04, 8'h00);
        xfer(8'hC7, 8'h00);
        xfer(8'h60, 8'h00);
        cs_off();
        expect_evt("R8 write enable", 4'd1, 8'h06, 24'h0, 8'h06);
        expect_evt("R8 write disable same frame", 4'd1, 8'h04, 24'h0, 8'h04);
        expect_evt("R3 alt chip erase normalised", 4'd1, 8'h60, 24'h0, 8'hC7);
        expect_evt("R3 chip erase", 4'd1, 8'h60, 24'h0, 8'h60);
        expect_none("R8 nothing extra");
    endtask

    task automatic t_read();
        cs_on();
        xfer(8'h03, 8'h00);
        xfer(8'h12, 8'h00);
        xfer(8'h34, 8'h00);
        xfer(8'h56, 8'h00);
        xfer(8'hFF, 8'hA1);
        xfer(8'hFF, 8'hB2);
        cs_off();
        expect_evt("R2 read opcode", 4'd1, 8'h03, 24'h0, 8'h03);
        expect_evt("R4 read address msb first", 4'd2, 8'h03, 24'h123456, 8'h00);
        expect_evt("R6 read data from miso", 4'd3, 8'h03, 24'h123456, 8'hA1);
        expect_evt("R6 read data second", 4'd3, 8'h03, 24'h123456, 8'hB2);
        expect_none("R6 read end");
    endtask

    task automatic t_fast_read();
        cs_on();
        xfer(8'h0B, 8'h00);
        xfer(8'h00, 8'h00);
        xfer(8'h01, 8'h00);
        xfer(8'h00, 8'h00);
        xfer(8'h00, 8'hEE);
        xfer(8'h00, 8'hA5);
        cs_off();
        expect_evt("R2 fast read opcode", 4'd1, 8'h0B, 24'h0, 8'h0B);
        expect_evt("R4 fast read address", 4'd2, 8'h0B, 24'h000100, 8'h00);
        expect_evt("R6 fast read skips dummy", 4'd3, 8'h0B, 24'h000100, 8'hA5);
        expect_none("R6 fast read end");
    endtask

    task automatic t_program();
        cs_on();
        xfer(8'h02, 8'h00);
        xfer(8'hAB, 8'h00);
        xfer(8'hCD, 8'h00);
        xfer(8'hEF, 8'h00);
        xfer(8'h5A, 8'h99);
        cs_off();
        expect_evt("R2 program opcode", 4'd1, 8'h02, 24'h0, 8'h02);
        expect_evt("R4 program address", 4'd2, 8'h02, 24'hABCDEF, 8'h00);
        expect_evt("R6 program data from mosi", 4'd4, 8'h02, 24'hABCDEF, 8'h5A);
        expect_none("R6 program end");
    endtask

    task automatic t_erase();
        cs_on();
        xfer(8'h20, 8'h00);
        xfer(8'h00, 8'h00);
        xfer(8'h30, 8'h00);
        xfer(8'h00, 8'h00);
        xfer(8'h20, 8'h00);
        xfer(8'h00, 8'h00);
        xfer(8'h30, 8'h00);
        xfer(8'h10, 8'h00);
        xfer(8'hD8, 8'h00);
        xfer(8'h01, 8'h00);
        xfer(8'h00, 8'h00);
        xfer(8'h04, 8'h00);
        cs_off();
        expect_evt("R2 erase opcode", 4'd1, 8'h20, 24'h0, 8'h20);
        expect_evt("R4 aligned erase address", 4'd2, 8'h20, 24'h003000, 8'h00);
        expect_evt("R2 erase opcode again", 4'd1, 8'h20, 24'h0, 8'h20);
        expect_evt("R5 misaligned erase warning", 4'd8, 8'h20, 24'h003010, 8'h00);
        expect_evt("R2 block erase opcode", 4'd1, 8'hD8, 24'h0, 8'hD8);
        expect_evt("R4 block erase address", 4'd2, 8'hD8, 24'h010004, 8'h00);
        expect_none("R5 erase end");
    endtask

    task automatic t_unknown();
        cs_on();
        xfer(8'hAA, 8'h00);
        xfer(8'h06, 8'h00);
        cs_off();
        expect_evt("R7 unknown opcode", 4'd7, 8'hAA, 24'h0, 8'hAA);
        expect_evt("R7 next byte is opcode", 4'd1, 8'h06, 24'h0, 8'h06);
        expect_none("R7 end");
    endtask

    task automatic t_id_status();
        cs_on();
        xfer(8'h9F, 8'h00);
        xfer(8'h00, 8'hC2);
        xfer(8'h00, 8'h20);
        xfer(8'h00, 8'h16);
        xfer(8'h05, 8'h00);
        xfer(8'h00, 8'h03);
        xfer(8'h00, 8'h83);
        cs_off();
        cs_on();
        xfer(8'h01, 8'h00);
        xfer(8'h5C, 8'h00);
        cs_off();
        expect_evt("R9 id opcode", 4'd1, 8'h9F, 24'h0, 8'h9F);
        expect_evt("R9 id byte 1", 4'd5, 8'h9F, 24'd1, 8'hC2);
        expect_evt("R9 id byte 2", 4'd5, 8'h9F, 24'd2, 8'h20);
        expect_evt("R9 id byte 3", 4'd5, 8'h9F, 24'd3, 8'h16);
        expect_evt("R9 status opcode after id", 4'd1, 8'h05, 24'h0, 8'h05);
        expect_evt("R9 status first", 4'd6, 8'h05, 24'h0, 8'h03);
        expect_evt("R9 status repeated", 4'd6, 8'h05, 24'h0, 8'h83);
        expect_evt("R9 write status opcode", 4'd1, 8'h01, 24'h0, 8'h01);
        expect_evt("R9 write status value", 4'd4, 8'h01, 24'h0, 8'h5C);
        expect_none("R9 end");
    endtask

    task automatic t_trunc();
        cs_on();
        xfer(8'h20, 8'h00);
        xfer(8'h01, 8'h00);
        cs_off();
        expect_evt("R11 erase opcode", 4'd1, 8'h20, 24'h0, 8'h20);
        expect_evt("R11 truncation", 4'd9, 8'h20, 24'h000001, 8'd2);
        expect_none("R11 end");
    endtask

    task automatic t_cs_frame();
        cs_on();
        xfer(8'h03, 8'h00);
        xfer(8'h00, 8'h00);
        xfer(8'h00, 8'h00);
        xfer(8'h10, 8'h00);
        xfer(8'h00, 8'h11);
        cs_off();
        xfer(8'h06, 8'h00);
        repeat (3) @(negedge clk);
        cs_on();
        xfer(8'h06, 8'h00);
        cs_off();
        expect_evt("R10 read opcode", 4'd1, 8'h03, 24'h0, 8'h03);
        expect_evt("R10 read address", 4'd2, 8'h03, 24'h000010, 8'h00);
        expect_evt("R10 read data", 4'd3, 8'h03, 24'h000010, 8'h11);
        expect_evt("R10 new frame starts with opcode", 4'd1, 8'h06, 24'h0, 8'h06);
        expect_none("R10 deselected byte ignored");
    endtask

    task automatic t_saturate();
        cs_on();
        xfer(8'h03, 8'h00);
        xfer(8'h00, 8'h00);
        xfer(8'h00, 8'h00);
        xfer(8'h40, 8'h00);
        for (int i = 0; i < 24; i++) xfer(8'h06, 8'(i + 1));
        cs_off();
        expect_evt("R13 opcode", 4'd1, 8'h03, 24'h0, 8'h03);
        expect_evt("R13 address", 4'd2, 8'h03, 24'h000040, 8'h00);
        for (int i = 0; i < 24; i++)
            expect_evt("R13 long burst data", 4'd3, 8'h03, 24'h000040, 8'(i + 1));
        expect_none("R13 end");
    endtask

    task automatic t_stall();
        @(negedge clk);
        evt_ready = 1'b0;
        cs_on();
        xfer(8'h06, 8'h00);
        xfer(8'h04, 8'h00);
        @(negedge clk);
        chk(evt_valid && evt_opcode == 8'h06 && evt_type == 4'd1, "R12 held event",
            44'({evt_valid, evt_type, evt_opcode}), 44'({1'b1, 4'd1, 8'h06}));
        chk(overflow == 1'b1, "R12 overflow set", 44'(overflow), 44'd1);
        evt_ready = 1'b1;
        cs_off();
        expect_evt("R12 stalled event delivered", 4'd1, 8'h06, 24'h0, 8'h06);
        expect_none("R12 dropped event gone");
        chk(overflow == 1'b1, "R12 overflow sticky", 44'(overflow), 44'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_read();
        t_fast_read();
        t_program();
        t_erase();
        t_unknown();
        t_id_status();
        t_trunc();
        t_cs_frame();
        t_saturate();
        t_stall();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule